// File: doc/BRIEF.md
# Microcontroller Core Register Bank

This block keeps the core control registers of an 8-bit accumulator machine. It holds the accumulator, a second operand register, the stack pointer, a 24-bit data pointer built from three bytes, the status word and the power-control byte. An instruction sequencer reaches these registers through a byte-wide control-register bus. The bus has an address, a write strobe, write data and combinational read data. It also has single-bit set and clear for the registers that allow bit access.

Three strobes act on the pointers without going through the bus:
- **Push** pre-increments the stack pointer.
- **Pop** post-decrements the stack pointer.
- **Data-pointer increment** runs a 16-bit increment whose carry feeds the page byte.

The block drives the current stack address, the whole data pointer, the selected register bank and the idle and power-down requests to the rest of the core.

Top module: `mcu_core_regs`

## Requirements
- R1: After reset the stack pointer reads 07H, and every other register reads 00H.
- R2: With push high, stk_addr equals SP+1 in the same cycle and SP holds that value after the edge, so the first push after reset addresses 08H. Push overrides pop.
- R3: With pop high and push low, stk_addr equals SP, and SP becomes SP-1 modulo 256 after the edge (00H goes to FFH).
- R4: The data pointer bytes are written and read at these addresses: low 82H, high 83H, page 84H. dptr is {page, high, low}.
- R5: dp_inc adds one to {high, low}. A carry out of the high byte adds one to the page, and the page wraps from FFH to 00H.
- R6: A bus write to SP (81H) wins over push and pop in the same cycle. A bus write to any data-pointer byte cancels that cycle's increment.
- R7: The status word at D0H holds these fields: bit 7 carry, bit 6 aux carry, bit 5 flag, bits 4:3 bank select, bit 2 overflow, bit 1 flag, bit 0 parity. reg_bank equals bits 4:3.
- R8: Status bit 0 always reads as the XOR of the eight accumulator bits, and writes to it are ignored.
- R9: Bit set and clear act on the bit rb_bit_idx of the registers at E0H, F0H and D0H. Clear overrides set. Both are ignored while rb_we is high, and ignored at every other address.
- R10: The power-control byte at 87H reads bits 6:5 as 0 whatever is written. pwr_idle_req equals its bit 0 and pwr_down_req equals its bit 1.
- R11: Reads from any address outside E0H, F0H, D0H, 87H and 81H–84H return 00H.
- R12: The accumulator (E0H) and operand register (F0H) read back the last byte written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rb_addr | input | 8 | Register bus address |
| rb_we | input | 1 | Register bus write strobe |
| rb_wdata | input | 8 | Register bus write data |
| rb_bit_set | input | 1 | Set one bit of the addressed register |
| rb_bit_clr | input | 1 | Clear one bit of the addressed register |
| rb_bit_idx | input | 3 | Bit index for set/clear |
| stk_push | input | 1 | Push strobe |
| stk_pop | input | 1 | Pop strobe |
| dp_inc | input | 1 | Data-pointer increment strobe |
| rb_rdata | output | 8 | Combinational read data |
| stk_addr | output | 8 | Stack RAM address for this cycle |
| dptr | output | 24 | Data pointer {page, high, low} |
| reg_bank | output | 2 | Selected register bank |
| pwr_idle_req | output | 1 | Idle mode request |
| pwr_down_req | output | 1 | Power-down request |

## Verification
Read data and the stack address are combinational. They are due in the same cycle as the address and strobes that produce them. Every write, bit operation and pointer strobe becomes visible one clock edge later. Reset release passes through two synchronizer flops before any register can change. The bench drives inputs on the falling edge and compares all outputs against its reference model one time unit later. It updates the model at the rising edge, so each result is checked in exactly the cycle it is due.

// File: rtl/mcu_regs_pkg.sv
package mcu_regs_pkg;
  localparam int DW = 8;
  localparam int AW = 8;
  localparam int BW = $clog2(DW);
  localparam int DP_BYTES = 3;
  localparam int DPW = DW * DP_BYTES;
  localparam int NGEN = 4;

  localparam logic [AW-1:0] A_ACC  = 8'hE0;
  localparam logic [AW-1:0] A_OPB  = 8'hF0;
  localparam logic [AW-1:0] A_STAT = 8'hD0;
  localparam logic [AW-1:0] A_PWR  = 8'h87;
  localparam logic [AW-1:0] A_SP   = 8'h81;
  localparam logic [AW-1:0] A_DPLO = 8'h82;
  localparam logic [AW-1:0] A_DPHI = 8'h83;
  localparam logic [AW-1:0] A_DPPG = 8'h84;

  localparam logic [DW-1:0] SP_RST    = 8'h07;
  localparam logic [DW-1:0] STAT_MASK = 8'hFE;
  localparam logic [DW-1:0] PWR_MASK  = 8'h9F;

  // generic byte registers: index 0 acc, 1 operand, 2 status, 3 power
  localparam int G_ACC = 0;
  localparam int G_OPB = 1;
  localparam int G_STAT = 2;
  localparam int G_PWR = 3;
  localparam logic [NGEN-1:0][AW-1:0] GEN_ADDR = {A_PWR, A_STAT, A_OPB, A_ACC};
  localparam logic [NGEN-1:0][DW-1:0] GEN_MASK = {PWR_MASK, STAT_MASK, 8'hFF, 8'hFF};
  localparam logic [NGEN-1:0]         GEN_BIT  = 4'b0111;
endpackage

// File: rtl/mcu_sfr_reg.sv
module mcu_sfr_reg
  import mcu_regs_pkg::*;
#(
  parameter logic [DW-1:0] RST_VAL = '0,
  parameter logic [DW-1:0] WMASK   = '1,
  parameter bit            BIT_OK  = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          bset,
  input  logic          bclr,
  input  logic [BW-1:0] bsel,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_n;
  logic [DW-1:0] bit_oh;
  logic          bit_op;
  logic          en;

  assign bit_oh = {{(DW-1){1'b0}}, 1'b1} << bsel;
  assign bit_op = BIT_OK && (bset || bclr);
  assign en     = wr_en || bit_op;

  always_comb begin
    q_n = q;
    if (wr_en) begin
      q_n = wdata & WMASK;
    end else if (bit_op) begin
      q_n = (bclr ? (q & ~bit_oh) : (q | bit_oh)) & WMASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL & WMASK;
    else if (en) q <= q_n;
  end

  assert_masked_bits_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (q & ~WMASK) == '0);
  assert_bit_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (BIT_OK && !wr_en && bclr) |=> (q[$past(bsel)] == 1'b0));
  assert_write_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> q == ($past(wdata) & WMASK));
endmodule

// File: rtl/mcu_stack_ptr.sv
module mcu_stack_ptr
  import mcu_regs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          push,
  input  logic          pop,
  output logic [DW-1:0] sp_q,
  output logic [DW-1:0] stk_addr
);
  logic [DW-1:0] sp_n;
  logic [DW-1:0] sp_up;
  logic          en;

  assign sp_up    = sp_q + 1'b1;
  assign stk_addr = push ? sp_up : sp_q;
  assign en       = wr_en || push || pop;

  always_comb begin
    sp_n = sp_q;
    if (wr_en)     sp_n = wdata;
    else if (push) sp_n = sp_up;
    else if (pop)  sp_n = sp_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= SP_RST;
    else if (en) sp_q <= sp_n;
  end

  assert_push_preinc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !wr_en) |=> sp_q == $past(stk_addr));
  assert_pop_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !wr_en) |=> sp_q == $past(sp_q) - 8'd1);
  assert_write_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sp_q == $past(wdata));
endmodule

// File: rtl/mcu_data_ptr.sv
module mcu_data_ptr
  import mcu_regs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DP_BYTES-1:0] wr_en,
  input  logic [DW-1:0]       wdata,
  input  logic                inc,
  output logic [DPW-1:0]      dptr
);
  logic [DP_BYTES-1:0][DW-1:0] dp_q;
  logic [DP_BYTES-1:0][DW-1:0] dp_n;
  logic [DPW-1:0]              dp_plus;
  logic                        any_wr;
  logic                        do_inc;

  assign any_wr  = |wr_en;
  assign do_inc  = inc && !any_wr;
  // a 24-bit +1 carries from the high byte straight into the page byte
  assign dp_plus = dp_q + 1'b1;
  assign dptr    = dp_q;

  for (genvar i = 0; i < DP_BYTES; i++) begin : g_byte
    always_comb begin
      dp_n[i] = dp_q[i];
      if (wr_en[i])    dp_n[i] = wdata;
      else if (do_inc) dp_n[i] = dp_plus[i*DW +: DW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dp_q[i] <= '0;
      else if (wr_en[i] || do_inc) dp_q[i] <= dp_n[i];
    end
  end

  assert_dptr_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !any_wr && dp_q[1] == 8'hFF && dp_q[0] == 8'hFF) |=>
      (dp_q[1] == 8'h00 && dp_q[0] == 8'h00 && dp_q[2] == $past(dp_q[2]) + 8'd1));
  assert_write_beats_inc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && any_wr && !wr_en[0]) |=> $stable(dp_q[0]));
endmodule

// File: rtl/mcu_core_regs.sv
module mcu_core_regs
  import mcu_regs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  rb_addr,
  input  logic        rb_we,
  input  logic [7:0]  rb_wdata,
  input  logic        rb_bit_set,
  input  logic        rb_bit_clr,
  input  logic [2:0]  rb_bit_idx,
  input  logic        stk_push,
  input  logic        stk_pop,
  input  logic        dp_inc,
  output logic [7:0]  rb_rdata,
  output logic [7:0]  stk_addr,
  output logic [23:0] dptr,
  output logic [1:0]  reg_bank,
  output logic        pwr_idle_req,
  output logic        pwr_down_req
);
  logic                        rst_meta_n;
  logic                        rst_sync_n;
  logic [NGEN-1:0][DW-1:0]     gen_q;
  logic [DW-1:0]               sp_q;
  logic [DP_BYTES-1:0]         dp_wr;
  logic                        addr_hit;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  for (genvar g = 0; g < NGEN; g++) begin : g_reg
    logic sel;
    assign sel = (rb_addr == GEN_ADDR[g]);
    mcu_sfr_reg #(
      .RST_VAL(8'h00),
      .WMASK  (GEN_MASK[g]),
      .BIT_OK (GEN_BIT[g])
    ) u_reg (
      .clk  (clk),
      .rst_n(rst_sync_n),
      .wr_en(rb_we && sel),
      .wdata(rb_wdata),
      .bset (rb_bit_set && sel),
      .bclr (rb_bit_clr && sel),
      .bsel (rb_bit_idx),
      .q    (gen_q[g])
    );
  end

  mcu_stack_ptr u_sp (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (rb_we && (rb_addr == A_SP)),
    .wdata   (rb_wdata),
    .push    (stk_push),
    .pop     (stk_pop),
    .sp_q    (sp_q),
    .stk_addr(stk_addr)
  );

  assign dp_wr[0] = rb_we && (rb_addr == A_DPLO);
  assign dp_wr[1] = rb_we && (rb_addr == A_DPHI);
  assign dp_wr[2] = rb_we && (rb_addr == A_DPPG);

  mcu_data_ptr u_dp (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .wr_en(dp_wr),
    .wdata(rb_wdata),
    .inc  (dp_inc),
    .dptr (dptr)
  );

  always_comb begin
    addr_hit = 1'b1;
    unique case (rb_addr)
      A_ACC:  rb_rdata = gen_q[G_ACC];
      A_OPB:  rb_rdata = gen_q[G_OPB];
      A_STAT: rb_rdata = {gen_q[G_STAT][7:1], ^gen_q[G_ACC]};
      A_PWR:  rb_rdata = gen_q[G_PWR];
      A_SP:   rb_rdata = sp_q;
      A_DPLO: rb_rdata = dptr[7:0];
      A_DPHI: rb_rdata = dptr[15:8];
      A_DPPG: rb_rdata = dptr[23:16];
      default: begin
        rb_rdata = '0;
        addr_hit = 1'b0;
      end
    endcase
  end

  assign reg_bank     = gen_q[G_STAT][4:3];
  assign pwr_idle_req = gen_q[G_PWR][0];
  assign pwr_down_req = gen_q[G_PWR][1];

  assert_bank_follows_write_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rb_we && rb_addr == A_STAT) |=> reg_bank == $past(rb_wdata[4:3]));
  assert_sp_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rst_sync_n) |-> sp_q == SP_RST);
  assert_power_reqs_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rb_we && rb_addr == A_PWR) |=> {pwr_down_req, pwr_idle_req} == $past(rb_wdata[1:0]));
  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !addr_hit |-> rb_rdata == 8'h00);
endmodule

// File: tb/mcu_core_regs_tb_top.sv
module mcu_core_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  rb_addr, rb_wdata, rb_rdata, stk_addr;
  logic        rb_we, rb_bit_set, rb_bit_clr, stk_push, stk_pop, dp_inc;
  logic [2:0]  rb_bit_idx;
  logic [23:0] dptr;
  logic [1:0]  reg_bank;
  logic        pwr_idle_req, pwr_down_req;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  // reference state
  int m_acc, m_opb, m_stat, m_pwr, m_sp, m_lo, m_hi, m_pg;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcu_core_regs dut_i (
    .clk(clk), .rst_n(rst_n), .rb_addr(rb_addr), .rb_we(rb_we), .rb_wdata(rb_wdata),
    .rb_bit_set(rb_bit_set), .rb_bit_clr(rb_bit_clr), .rb_bit_idx(rb_bit_idx),
    .stk_push(stk_push), .stk_pop(stk_pop), .dp_inc(dp_inc), .rb_rdata(rb_rdata),
    .stk_addr(stk_addr), .dptr(dptr), .reg_bank(reg_bank),
    .pwr_idle_req(pwr_idle_req), .pwr_down_req(pwr_down_req)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int parity8(input int v);
    int p = 0;
    for (int i = 0; i < 8; i++) p ^= (v >> i) & 1;
    return p;
  endfunction

  function automatic int exp_read(input int a);
    case (a)
      'hE0: return m_acc;
      'hF0: return m_opb;
      'hD0: return (m_stat & 'hFE) | parity8(m_acc);
      'h87: return m_pwr;
      'h81: return m_sp;
      'h82: return m_lo;
      'h83: return m_hi;
      'h84: return m_pg;
      default: return 0;
    endcase
  endfunction

  function automatic void model_reset();
    m_acc = 0; m_opb = 0; m_stat = 0; m_pwr = 0; m_sp = 'h07; m_lo = 0; m_hi = 0; m_pg = 0;
  endfunction

  function automatic int bitop(input int v, input int set, input int clr, input int idx);
    if (clr) return v & ~(1 << idx);
    if (set) return v | (1 << idx);
    return v;
  endfunction

  function automatic void model_step(input int we, input int a, input int wd, input int bs,
                                     input int bc, input int idx, input int push,
                                     input int pop, input int inc);
    int w16;
    bit dp_written;
    if (we) begin
      case (a)
        'hE0: m_acc = wd;
        'hF0: m_opb = wd;
        'hD0: m_stat = wd & 'hFE;
        'h87: m_pwr = wd & 'h9F;
        'h81: m_sp = wd;
        'h82: m_lo = wd;
        'h83: m_hi = wd;
        'h84: m_pg = wd;
        default: ;
      endcase
    end else if (bs || bc) begin
      case (a)
        'hE0: m_acc = bitop(m_acc, bs, bc, idx);
        'hF0: m_opb = bitop(m_opb, bs, bc, idx);
        'hD0: m_stat = bitop(m_stat, bs, bc, idx) & 'hFE;
        default: ;
      endcase
    end
    if (!(we && a == 'h81)) begin
      if (push) m_sp = (m_sp + 1) & 'hFF;
      else if (pop) m_sp = (m_sp + 255) & 'hFF;
    end
    dp_written = we && (a >= 'h82) && (a <= 'h84);
    if (inc && !dp_written) begin
      w16 = (m_hi << 8) + m_lo + 1;
      if (w16 > 'hFFFF) m_pg = (m_pg + 1) & 'hFF;
      m_hi = (w16 >> 8) & 'hFF;
      m_lo = w16 & 'hFF;
    end
  endfunction

  // one cycle: drive at falling edge, compare, advance model at rising edge
  task automatic cyc(input string req, input int we, input int a, input int wd,
                     input int bs = 0, input int bc = 0, input int idx = 0,
                     input int push = 0, input int pop = 0, input int inc = 0);
    rb_we = we[0]; rb_addr = a[7:0]; rb_wdata = wd[7:0];
    rb_bit_set = bs[0]; rb_bit_clr = bc[0]; rb_bit_idx = idx[2:0];
    stk_push = push[0]; stk_pop = pop[0]; dp_inc = inc[0];
    #1;
    chk(req, "rb_rdata", int'(rb_rdata), exp_read(a));
    chk("R2", "stk_addr", int'(stk_addr), push ? ((m_sp + 1) & 'hFF) : m_sp);
    chk("R4", "dptr", int'(dptr), (m_pg << 16) | (m_hi << 8) | m_lo);
    chk("R7", "reg_bank", int'(reg_bank), (m_stat >> 3) & 3);
    chk("R10", "pwr_reqs", int'({pwr_down_req, pwr_idle_req}), m_pwr & 3);
    @(posedge clk);
    model_step(we, a, wd, bs, bc, idx, push, pop, inc);
    @(negedge clk);
  endtask

  task automatic rd(input string req, input int a);
    cyc(req, 0, a, 0);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : stim
    int lfsr;
    int maddr[10] = '{'hE0, 'hF0, 'hD0, 'h87, 'h81, 'h82, 'h83, 'h84, 'h85, 'h00};
    rst_n = 1'b0;
    rb_we = 0; rb_addr = 0; rb_wdata = 0; rb_bit_set = 0; rb_bit_clr = 0;
    rb_bit_idx = 0; stk_push = 0; stk_pop = 0; dp_inc = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset values
    foreach (maddr[i]) rd("R1", maddr[i]);

    // R12: accumulator and operand register
    cyc("R12", 1, 'hE0, 'h5A); rd("R12", 'hE0);
    cyc("R12", 1, 'hF0, 'hC3); rd("R12", 'hF0);

    // R2: pushes from reset value give 08H then 09H
    cyc("R2", 0, 'h81, 0, 0, 0, 0, 1); cyc("R2", 0, 'h81, 0, 0, 0, 0, 1); rd("R2", 'h81);
    // R3: pop and wrap
    cyc("R3", 0, 'h81, 0, 0, 0, 0, 0, 1); rd("R3", 'h81);
    cyc("R3", 1, 'h81, 'h00); cyc("R3", 0, 'h81, 0, 0, 0, 0, 0, 1); rd("R3", 'h81);
    // R2: push overrides pop
    cyc("R2", 0, 'h81, 0, 0, 0, 0, 1, 1); rd("R2", 'h81);
    // R6: SP write wins over push and pop
    cyc("R6", 1, 'h81, 'h40, 0, 0, 0, 1); rd("R6", 'h81);
    cyc("R6", 1, 'h81, 'h20, 0, 0, 0, 0, 1); rd("R6", 'h81);

    // R4: data pointer bytes
    cyc("R4", 1, 'h82, 'hFF); cyc("R4", 1, 'h83, 'hFF); cyc("R4", 1, 'h84, 'h12);
    rd("R4", 'h82); rd("R4", 'h83); rd("R4", 'h84);
    // R5: carry into page, then page wrap
    cyc("R5", 0, 'h84, 0, 0, 0, 0, 0, 0, 1); rd("R5", 'h84);
    cyc("R5", 1, 'h82, 'hFE); cyc("R5", 0, 'h82, 0, 0, 0, 0, 0, 0, 1); rd("R5", 'h82);
    cyc("R5", 1, 'h82, 'hFF); cyc("R5", 1, 'h83, 'hFF); cyc("R5", 1, 'h84, 'hFF);
    cyc("R5", 0, 'h84, 0, 0, 0, 0, 0, 0, 1); rd("R5", 'h84);
    // R6: write to one byte cancels increment
    cyc("R6", 1, 'h84, 'h33, 0, 0, 0, 0, 0, 1); rd("R6", 'h82); rd("R6", 'h84);

    // R7: status word and bank
    cyc("R7", 1, 'hD0, 'h18); rd("R7", 'hD0); cyc("R7", 1, 'hD0, 'h08); rd("R7", 'hD0);
    // R8: parity from accumulator, write to bit 0 ignored
    cyc("R8", 1, 'hE0, 'h01); rd("R8", 'hD0); cyc("R8", 1, 'hD0, 'hFF); rd("R8", 'hD0);
    cyc("R8", 1, 'hE0, 'h03); rd("R8", 'hD0);
    cyc("R8", 0, 'hD0, 0, 1, 0, 0); rd("R8", 'hD0);

    // R9: bit operations
    cyc("R9", 0, 'hF0, 0, 1, 0, 2); rd("R9", 'hF0);
    cyc("R9", 0, 'hF0, 0, 0, 1, 7); rd("R9", 'hF0);
    cyc("R9", 0, 'hF0, 0, 1, 1, 0); rd("R9", 'hF0);
    cyc("R9", 1, 'hE0, 'h80, 1, 0, 0); rd("R9", 'hE0);
    cyc("R9", 0, 'hD0, 0, 0, 1, 4); rd("R9", 'hD0);
    cyc("R9", 0, 'h87, 0, 1, 0, 0); rd("R9", 'h87);
    cyc("R9", 0, 'h81, 0, 1, 0, 7); rd("R9", 'h81);

    // R10: power control
    cyc("R10", 1, 'h87, 'hFF); rd("R10", 'h87);
    cyc("R10", 1, 'h87, 'h02); rd("R10", 'h87);
    cyc("R10", 1, 'h87, 'h61); rd("R10", 'h87);

    // R11: unmapped addresses
    rd("R11", 'h00); rd("R11", 'h85); rd("R11", 'hFF); rd("R11", 'h86);
    cyc("R11", 1, 'h85, 'hAA); rd("R11", 'h85);

    // mixed traffic
    lfsr = 32'h1ACE;
    for (int n = 0; n < 400; n++) begin
      int r;
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      r = lfsr;
      cyc("R6", (r >> 2) & 1, maddr[(r >> 4) % 10], (r >> 8) & 'hFF, (r >> 3) & 1,
          ((r >> 1) & (r >> 5)) & 1, (r >> 11) & 7, (r >> 6) & 1, (r >> 7) & 1, r & 1);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule